// File: doc/BRIEF.md
# Cache Tag Store with Match

This block is the tag memory of a secondary cache. It keeps a 12-bit tag and three status flags for every line index. It compares the tag stored at the addressed line with an incoming tag and raises a hit. The lookup is combinational: the stored tag, the stored flags and the hit all follow the index and tag inputs within the same cycle. Tag and flag updates happen only on the rising clock edge, and each group has its own write enable.

An active-low synchronous reset clears the flags of every line in one clock. This invalidates the whole cache and leaves the stored tags as they were. A mode input chooses how the flags are used:

- **Dedicated mode:** the valid flag qualifies the hit and the write-through flag steers the burst-ready output.
- **Generic mode:** the flags are stored and returned as plain user bits and have no effect on the hit or on ready.

Two selects must both be high before the block writes or drives the hit and ready outputs active. This lets several instances share a wider index space. The tag, flag and ready outputs each have their own output enable, and a disabled output reads as all zeros. All pins are plain level signals with no handshake.

Top module: `tagstore_top`

## Requirements
- R1: With `oe_tag` high, `tag_out` shows the tag stored at `idx` in the same cycle that `idx` changes, with no clock edge in between.
- R2: At a rising edge where `sel_a`, `sel_b` and `tag_we` are high, `tag_in` is stored at `idx`. The flags of that line are unchanged.
- R3: At a rising edge where `sel_a`, `sel_b` and `stat_we` are high and `rst_n` is high, `stat_in` is stored at `idx`. The tag of that line is unchanged. Flag bit 0 is valid, bit 1 is dirty and bit 2 is write-through.
- R4: In dedicated mode (`generic_mode` low), `match` is 1 exactly when both selects are high, the stored tag equals `tag_in`, and the stored valid bit (bit 0) is 1.
- R5: In generic mode (`generic_mode` high), `match` depends only on the selects and tag equality, and all three flag bits are written and read back as given.
- R6: A rising edge with `rst_n` low clears the flags of every line to 0 and leaves every stored tag unchanged.
- R7: If `rst_n` is low at the same edge as a selected flag write, the flags become 0. A selected tag write at that edge still completes.
- R8: In dedicated mode, `brdy` is 1 exactly when `match`, `oe_rdy` and `rdy_qual` are all 1, and either `cyc_write` is 0 or the stored write-through bit (bit 2) is 0.
- R9: In generic mode, `brdy` is 1 exactly when `match`, `oe_rdy` and `rdy_qual` are all 1, whatever the write-through bit and `cyc_write` are.
- R10: If either select is low, `match` and `brdy` are 0 and a rising edge writes neither tags nor flags.
- R11: `oe_tag` low forces `tag_out` to 0, `oe_stat` low forces `stat_out` to 0, and `oe_rdy` low forces `brdy` to 0. Each enable acts independently of the others and of `match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and the flag clear happen on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all flags |
| sel_a | input | 1 | First select, active high |
| sel_b | input | 1 | Second select, active high |
| idx | input | IDX_W | Line index |
| tag_in | input | TAG_W | Tag to compare and to write |
| tag_we | input | 1 | Tag write enable |
| stat_in | input | 3 | Flags to write (bit 0 valid, 1 dirty, 2 write-through) |
| stat_we | input | 1 | Flag write enable |
| generic_mode | input | 1 | 1 = flags are plain user bits, 0 = dedicated meanings |
| cyc_write | input | 1 | Current bus cycle is a write |
| rdy_qual | input | 1 | External qualifier for burst-ready |
| oe_tag | input | 1 | Output enable for tag_out |
| oe_stat | input | 1 | Output enable for stat_out |
| oe_rdy | input | 1 | Output enable for brdy |
| tag_out | output | TAG_W | Stored tag at idx |
| stat_out | output | 3 | Stored flags at idx |
| match | output | 1 | Hit |
| brdy | output | 1 | Burst-ready |

## Verification
A corrupt tag or flag entry shows at the ports at once, because the read path is combinational. As soon as `idx` points at the bad line, `tag_out` and `stat_out` show it and `match` takes the wrong value in that same cycle. A write that lands on the wrong line, or a flag clear that misses some entries, shows after one edge when the affected line is selected. A wrong reading of the write-through or valid bit shows as a wrong `brdy` on the very next lookup of that line.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
  localparam int STAT_W   = 3;
  localparam int BIT_VLD  = 0;
  localparam int BIT_DRT  = 1;
  localparam int BIT_WTH  = 2;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/tag_array.sv
module tag_array #(
  parameter int DEPTH = 1024,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rdata
);
  // tag storage carries no reset: only flags are cleared
  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/status_array.sv
module status_array
  import tagstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  stat_t            wdata,
  output stat_t            rdata
);
  stat_t flags [DEPTH];

  // one register per line so the whole array clears in a single edge
  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!clr_n)
        flags[i] <= '0;
      else if (we && (idx == IDX_W'(i)))
        flags[i] <= wdata;
    end
  end

  assign rdata = flags[idx];
endmodule

// File: rtl/hit_logic.sv
module hit_logic #(
  parameter int TAG_W = 12
) (
  input  logic [TAG_W-1:0] tag_rd,
  input  logic [TAG_W-1:0] tag_cmp,
  input  logic             vld_rd,
  input  logic             wth_rd,
  input  logic             selected,
  input  logic             generic_mode,
  input  logic             cyc_write,
  input  logic             rdy_qual,
  input  logic             oe_rdy,
  output logic             hit,
  output logic             rdy
);
  logic tag_eq;
  logic qualify;
  logic wr_blocked;

  always_comb begin
    tag_eq     = (tag_rd == tag_cmp);
    qualify    = generic_mode | vld_rd;
    hit        = selected & tag_eq & qualify;
    wr_blocked = ~generic_mode & cyc_write & wth_rd;
    rdy        = hit & rdy_qual & oe_rdy & ~wr_blocked;
  end
endmodule

// File: rtl/tagstore_top.sv
module tagstore_top
  import tagstore_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              tag_we,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              stat_we,
  input  logic              generic_mode,
  input  logic              cyc_write,
  input  logic              rdy_qual,
  input  logic              oe_tag,
  input  logic              oe_stat,
  input  logic              oe_rdy,
  output logic [TAG_W-1:0]  tag_out,
  output logic [STAT_W-1:0] stat_out,
  output logic              match,
  output logic              brdy
);
  logic             selected;
  logic [TAG_W-1:0] tag_rd;
  stat_t            stat_rd;

  assign selected = sel_a & sel_b;

  tag_array #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tags (
    .clk   (clk),
    .we    (selected & tag_we),
    .idx   (idx),
    .wdata (tag_in),
    .rdata (tag_rd)
  );

  status_array #(.DEPTH(DEPTH)) u_flags (
    .clk   (clk),
    .clr_n (rst_n),
    .we    (selected & stat_we),
    .idx   (idx),
    .wdata (stat_in),
    .rdata (stat_rd)
  );

  hit_logic #(.TAG_W(TAG_W)) u_hit (
    .tag_rd       (tag_rd),
    .tag_cmp      (tag_in),
    .vld_rd       (stat_rd[BIT_VLD]),
    .wth_rd       (stat_rd[BIT_WTH]),
    .selected     (selected),
    .generic_mode (generic_mode),
    .cyc_write    (cyc_write),
    .rdy_qual     (rdy_qual),
    .oe_rdy       (oe_rdy),
    .hit          (match),
    .rdy          (brdy)
  );

  assign tag_out  = oe_tag  ? tag_rd  : '0;
  assign stat_out = oe_stat ? stat_rd : '0;
endmodule

// File: rtl/tagstore_chk.sv
module tagstore_chk #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_a,
  input logic             sel_b,
  input logic [IDX_W-1:0] idx,
  input logic [TAG_W-1:0] tag_in,
  input logic             tag_we,
  input logic             stat_we,
  input logic             generic_mode,
  input logic             cyc_write,
  input logic             oe_rdy,
  input logic [TAG_W-1:0] tag_rd,
  input logic [2:0]       stat_rd,
  input logic             match,
  input logic             brdy
);
  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !generic_mode) |-> stat_rd[0]);

  // R10
  hit_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (sel_a && sel_b));

  // R8
  rdy_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brdy |-> (match && oe_rdy));

  // R8
  wt_write_blocks_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!generic_mode && cyc_write && stat_rd[2]) |-> !brdy);

  // R6
  clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stat_rd == 3'b000));

  // R2
  tag_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && sel_b && tag_we) |=> (!$stable(idx) || tag_rd == $past(tag_in)));

  // R10
  unselected_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel_a && sel_b) && stat_we) |=> (!$stable(idx) || $stable(stat_rd)));
endmodule

bind tagstore_top tagstore_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_a        (sel_a),
  .sel_b        (sel_b),
  .idx          (idx),
  .tag_in       (tag_in),
  .tag_we       (tag_we),
  .stat_we      (stat_we),
  .generic_mode (generic_mode),
  .cyc_write    (cyc_write),
  .oe_rdy       (oe_rdy),
  .tag_rd       (tag_rd),
  .stat_rd      (stat_rd),
  .match        (match),
  .brdy         (brdy)
);

// File: tb/tagstore_top_bench.sv
module tagstore_top_bench;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int TAG_W  = 12;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n, sel_a, sel_b, tag_we, stat_we, generic_mode, cyc_write;
  logic rdy_qual, oe_tag, oe_stat, oe_rdy;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag_in;
  logic [2:0] stat_in;
  logic [TAG_W-1:0] tag_out;
  logic [2:0] stat_out;
  logic match, brdy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tagstore_top #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tagstore_top (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .idx(idx),
    .tag_in(tag_in), .tag_we(tag_we), .stat_in(stat_in), .stat_we(stat_we),
    .generic_mode(generic_mode), .cyc_write(cyc_write), .rdy_qual(rdy_qual),
    .oe_tag(oe_tag), .oe_stat(oe_stat), .oe_rdy(oe_rdy),
    .tag_out(tag_out), .stat_out(stat_out), .match(match), .brdy(brdy)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_writes();
    tag_we = 1'b0; stat_we = 1'b0;
  endtask

  task automatic wr_tag(input int i, input logic [TAG_W-1:0] t);
    idx = IDX_W'(i); tag_in = t; tag_we = 1'b1; tick(); idle_writes();
  endtask

  task automatic wr_stat(input int i, input logic [2:0] s);
    idx = IDX_W'(i); stat_in = s; stat_we = 1'b1; tick(); idle_writes();
  endtask

  task automatic t_reset_state();
    idx = 0; settle();
    chk("R6 flags cleared idx0", 32'(stat_out), 32'h0);
    idx = 5; settle();
    chk("R6 flags cleared idx5", 32'(stat_out), 32'h0);
  endtask

  task automatic t_tag_write();
    wr_tag(3, 12'hABC);
    chk("R2 tag stored", 32'(tag_out), 32'hABC);
    chk("R2 flags untouched", 32'(stat_out), 32'h0);
    wr_tag(4, 12'h123);
    idx = 3; settle();
    chk("R1 combinational read", 32'(tag_out), 32'hABC);
  endtask

  task automatic t_stat_write();
    wr_stat(3, 3'b001);
    chk("R3 flags stored", 32'(stat_out), 32'h1);
    chk("R3 tag untouched", 32'(tag_out), 32'hABC);
    tag_in = 12'hABC; settle();
    chk("R4 hit on valid line", 32'(match), 32'h1);
    tag_in = 12'hABD; settle();
    chk("R4 miss on tag differ", 32'(match), 32'h0);
    idx = 4; tag_in = 12'h123; settle();
    chk("R4 miss on invalid line", 32'(match), 32'h0);
  endtask

  task automatic t_selects();
    idx = 3; tag_in = 12'hABC; sel_b = 1'b0; settle();
    chk("R10 no hit with sel_b low", 32'(match), 32'h0);
    chk("R10 no ready with sel_b low", 32'(brdy), 32'h0);
    sel_b = 1'b1; sel_a = 1'b0;
    wr_tag(3, 12'h555);
    wr_stat(3, 3'b000);
    sel_a = 1'b1; tag_in = 12'hABC; settle();
    chk("R10 tag not written", 32'(tag_out), 32'hABC);
    chk("R10 flags not written", 32'(stat_out), 32'h1);
  endtask

  task automatic t_ready();
    idx = 3; tag_in = 12'hABC; rdy_qual = 1'b1; cyc_write = 1'b0; settle();
    chk("R8 read hit ready", 32'(brdy), 32'h1);
    cyc_write = 1'b1; settle();
    chk("R8 write hit copy-back ready", 32'(brdy), 32'h1);
    wr_stat(3, 3'b101);
    tag_in = 12'hABC; settle();
    chk("R8 write hit write-through not ready", 32'(brdy), 32'h0);
    cyc_write = 1'b0; settle();
    chk("R8 read hit write-through ready", 32'(brdy), 32'h1);
    rdy_qual = 1'b0; settle();
    chk("R8 qualifier low", 32'(brdy), 32'h0);
    rdy_qual = 1'b1; tag_in = 12'h000; settle();
    chk("R8 miss not ready", 32'(brdy), 32'h0);
  endtask

  task automatic t_generic();
    generic_mode = 1'b1;
    idx = 4; tag_in = 12'h123; settle();
    chk("R5 hit ignores valid", 32'(match), 32'h1);
    wr_stat(4, 3'b110);
    chk("R5 user bits returned", 32'(stat_out), 32'h6);
    idx = 3; tag_in = 12'hABC; cyc_write = 1'b1; settle();
    chk("R9 write-through ignored", 32'(brdy), 32'h1);
    generic_mode = 1'b0; cyc_write = 1'b0;
    idx = 4; tag_in = 12'h123; settle();
    chk("R4 dedicated miss with valid clear", 32'(match), 32'h0);
  endtask

  task automatic t_output_enables();
    idx = 3; tag_in = 12'hABC; oe_tag = 1'b0; settle();
    chk("R11 tag disabled", 32'(tag_out), 32'h0);
    chk("R11 flags still on", 32'(stat_out), 32'h5);
    oe_tag = 1'b1; oe_stat = 1'b0; settle();
    chk("R11 flags disabled", 32'(stat_out), 32'h0);
    oe_stat = 1'b1; oe_rdy = 1'b0; settle();
    chk("R11 ready disabled", 32'(brdy), 32'h0);
    chk("R11 hit unaffected", 32'(match), 32'h1);
    oe_rdy = 1'b1;
  endtask

  task automatic t_reset_collision();
    idx = 3; tag_in = 12'h777; tag_we = 1'b1;
    stat_in = 3'b001; stat_we = 1'b1; rst_n = 1'b0;
    tick();
    idle_writes(); rst_n = 1'b1; settle();
    chk("R7 reset beats flag write", 32'(stat_out), 32'h0);
    chk("R7 tag write completes", 32'(tag_out), 32'h777);
    chk("R7 no hit after clear", 32'(match), 32'h0);
    idx = 4; settle();
    chk("R6 other tag kept", 32'(tag_out), 32'h123);
    chk("R6 other flags cleared", 32'(stat_out), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; sel_a = 1'b1; sel_b = 1'b1; idx = '0; tag_in = '0;
    tag_we = 1'b0; stat_in = '0; stat_we = 1'b0; generic_mode = 1'b0;
    cyc_write = 1'b0; rdy_qual = 1'b0; oe_tag = 1'b1; oe_stat = 1'b1; oe_rdy = 1'b1;
    @(negedge clk); tick(); tick();
    rst_n = 1'b1; tick();
    t_reset_state();
    t_tag_write();
    t_stat_write();
    t_selects();
    t_ready();
    t_generic();
    t_output_enables();
    t_reset_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule